// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave

This block is the slave side of a two-wire serial memory. It contains a byte-wide storage array of 256 words by default. It watches the clock and data lines of the bus through a two-flop synchroniser that runs on a faster system clock, and it pulls the data line low through an open-drain enable. After a start condition it takes in an address byte. This byte carries a fixed device code, three strap-compared bits and a read/write flag. A matching write command then loads the word pointer and stores data bytes. A matching read command shifts stored bytes out for as long as the master acknowledges them.

Written bytes are collected in a small pending buffer and reach the array only when a stop condition closes the command. A start condition received in the middle of a command throws the pending bytes away. A parameter can turn the lowest strap positions into page-select bits. These bits extend the word pointer above bit 7, so that larger arrays can be addressed.

Top module: `ee_slave`

## Requirements
- R1: After reset the open-drain enable `sda_oe_o` is low and the block waits for a start condition.
- R2: The address byte after a start is taken MSB first. Bits [7:4] must be 1010 and bits [3:1] must equal `strap_i[2:0]`, and bit 0 is the read flag (1 = read). On a match the block pulls SDA low on the 9th clock. On a mismatch it leaves SDA released for the rest of the command and ignores every later byte until the next start.
- R3: In a write command the word-address byte and every data byte are acknowledged. Data byte k of the command is stored at word address + k.
- R4: Written bytes reach the array only at a stop condition. A start that arrives before the stop discards them.
- R5: A random read returns the byte at the given word address. It is sent as a write-mode address byte, the word address, a repeated start and a read-mode address byte.
- R6: A read continues with the next address while the master acknowledges each byte. The pointer wraps from the top of the array to 0.
- R7: The word pointer advances by one after each byte read or written. A read-mode command without a word address starts at the pointer's present value.
- R8: When the master does not acknowledge a read byte, the block releases SDA and drives nothing until the next start or stop. A following command works normally.
- R9: A start condition seen in the middle of a byte aborts the current command, and the block takes the next byte as a fresh address byte.
- R10: One write command keeps at most `WR_BUF` (default 8) data bytes. Further bytes are acknowledged and dropped, but the pointer still advances for each of them.
- R11: `sda_oe_o` changes only while `scl_i` is low.
- R12: With `PAGE_BITS` = P, the lowest P positions of address bits [3:1], starting at bit 1, are excluded from the strap compare. They become word-address bits 8 and up, so equal word addresses on different pages hold separate bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| strap_i | input | 3 | Strap bits compared with address bits [3:1] |
| sda_oe_o | output | 1 | High pulls the data line low (open drain) |

## Verification
A wrong bit counter or state shows within a single byte: the acknowledge pulse lands on the wrong clock, or read data comes out shifted by a bit, so the master sees a missing ACK or a wrong byte at once. A pointer that advances wrongly does not show until a later current-address or sequential read returns a byte from the wrong location. A pending buffer that commits early or drops data shows only when the location is read back after a later stop. For this reason the memory is filled first, and every later read is compared with a model of that fill. The checker also watches the enable for any change while the clock is high, and for any drive outside an acknowledge slot or a read byte.

// File: rtl/ee_pkg.sv
package ee_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_WADDR,
    ST_WDATA,
    ST_READ,
    ST_IGN
  } ee_state_e;

  localparam logic [3:0] DEV_CODE = 4'b1010;
endpackage

// File: rtl/ee_line_sync.sv
module ee_line_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det,
  output logic sda_s
);
  logic [2:0] scl_q, scl_d;
  logic [2:0] sda_q, sda_d;

  always_comb begin
    scl_d = {scl_q[1:0], scl_i};
    sda_d = {sda_q[1:0], sda_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 3'b111;
      sda_q <= 3'b111;
    end else begin
      scl_q <= scl_d;
      sda_q <= sda_d;
    end
  end

  // stage 1 is the synchronised level, stage 2 the previous one
  assign sda_s     = sda_q[1];
  assign scl_rise  = scl_q[1] & ~scl_q[2];
  assign scl_fall  = ~scl_q[1] & scl_q[2];
  assign start_det = scl_q[1] & scl_q[2] & sda_q[2] & ~sda_q[1];
  assign stop_det  = scl_q[1] & scl_q[2] & ~sda_q[2] & sda_q[1];
endmodule

// File: rtl/ee_store.sv
module ee_store #(
  parameter int AW     = 8,
  parameter int WR_BUF = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic [AW-1:0] push_addr,
  input  logic [7:0]    push_data,
  input  logic          commit,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data
);
  localparam int DEPTH = 1 << AW;
  localparam int CW    = $clog2(WR_BUF + 1);

  logic [7:0]    mem    [DEPTH];
  logic [AW-1:0] b_addr [WR_BUF];
  logic [7:0]    b_data [WR_BUF];
  logic [CW-1:0] cnt, cnt_n;
  logic          push_ok;

  assign push_ok = push && (cnt < CW'(WR_BUF));

  always_comb begin
    cnt_n = cnt;
    if (clr || commit) cnt_n = '0;
    else if (push_ok)  cnt_n = cnt + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_n;
  end

  for (genvar g = 0; g < WR_BUF; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (push_ok && cnt == CW'(g)) begin
        b_addr[g] <= push_addr;
        b_data[g] <= push_data;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (commit) begin
      for (int i = 0; i < WR_BUF; i++) begin
        if (CW'(i) < cnt) mem[b_addr[i]] <= b_data[i];
      end
    end
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/ee_proto.sv
module ee_proto
  import ee_pkg::*;
#(
  parameter int PAGE_BITS = 0,
  parameter int AW        = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_det,
  input  logic          stop_det,
  input  logic          sda_s,
  input  logic [2:0]    strap,
  input  logic [7:0]    rd_data,
  output logic          sda_oe,
  output logic [AW-1:0] ptr,
  output logic          push,
  output logic [7:0]    push_data,
  output logic          clr,
  output logic          commit,
  output ee_state_e     st,
  output logic [3:0]    bitcnt
);
  localparam logic [2:0]    STRAP_MASK = 3'(3'b111 << PAGE_BITS);
  localparam logic [AW-1:0] LOW_MASK   = AW'(8'hFF);

  ee_state_e     st_n, after, after_n;
  logic [3:0]    bit_n;
  logic [6:0]    rx, rx_n;
  logic [7:0]    tx, tx_n, byte_in;
  logic          ack, ack_n, oe_n;
  logic [AW-1:0] ptr_n;
  logic          match;
  logic [2:0]    pg_in;

  assign byte_in   = {rx, sda_s};
  assign match     = (byte_in[7:4] == DEV_CODE) &&
                     (((byte_in[3:1] ^ strap) & STRAP_MASK) == 3'b000);
  assign pg_in     = byte_in[3:1] & ~STRAP_MASK;
  assign push_data = byte_in;

  always_comb begin
    st_n = st; after_n = after; bit_n = bitcnt; rx_n = rx; tx_n = tx;
    ack_n = ack; oe_n = sda_oe; ptr_n = ptr;
    push = 1'b0; clr = 1'b0; commit = 1'b0;
    if (start_det) begin
      st_n = ST_ADDR; bit_n = '0; oe_n = 1'b0; ack_n = 1'b0; clr = 1'b1;
    end else if (stop_det) begin
      st_n = ST_IDLE; oe_n = 1'b0; commit = 1'b1;
    end else if (st == ST_IDLE || st == ST_IGN) begin
      st_n = st;
    end else if (scl_rise) begin
      if (bitcnt == 4'd8) begin
        bit_n = '0;
        if (st == ST_READ) begin
          if (!sda_s) begin
            tx_n = rd_data; ptr_n = ptr + AW'(1);
          end else begin
            st_n = ST_IGN;
          end
        end else begin
          st_n = after;
          if (after == ST_READ) begin
            tx_n = rd_data; ptr_n = ptr + AW'(1);
          end
        end
      end else begin
        bit_n = bitcnt + 4'd1;
        rx_n  = byte_in[6:0];
        tx_n  = {tx[6:0], 1'b0};
        if (bitcnt == 4'd7) begin
          ack_n = 1'b1;
          unique case (st)
            ST_ADDR: begin
              if (match) begin
                after_n = byte_in[0] ? ST_READ : ST_WADDR;
                ptr_n   = AW'({pg_in, ptr[7:0]});
              end else begin
                after_n = ST_IGN; ack_n = 1'b0;
              end
            end
            ST_WADDR: begin
              after_n = ST_WDATA;
              ptr_n   = (ptr & ~LOW_MASK) | AW'(byte_in);
            end
            ST_WDATA: begin
              after_n = ST_WDATA; push = 1'b1; ptr_n = ptr + AW'(1);
            end
            default: ack_n = 1'b0;
          endcase
        end
      end
    end else if (scl_fall) begin
      if (bitcnt == 4'd8) oe_n = (st != ST_READ) && ack;
      else                oe_n = (st == ST_READ) && !tx[7];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; after <= ST_IGN; bitcnt <= '0; rx <= '0; tx <= '0;
      ack <= 1'b0; sda_oe <= 1'b0; ptr <= '0;
    end else begin
      st <= st_n; after <= after_n; bitcnt <= bit_n; rx <= rx_n; tx <= tx_n;
      ack <= ack_n; sda_oe <= oe_n; ptr <= ptr_n;
    end
  end
endmodule

// File: rtl/ee_slave.sv
module ee_slave
  import ee_pkg::*;
#(
  parameter int PAGE_BITS = 0,
  parameter int WR_BUF    = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] strap_i,
  output logic       sda_oe_o
);
  localparam int AW = 8 + PAGE_BITS;

  logic [1:0]    rst_q;
  logic          rst_int_n;
  logic          scl_rise, scl_fall, start_det, stop_det, sda_s;
  logic          push, clr, commit;
  logic [7:0]    push_data, rd_data;
  logic [AW-1:0] ptr;
  ee_state_e     st;
  logic [3:0]    bitcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_int_n = rst_q[1];

  ee_line_sync u_sync (
    .clk(clk), .rst_n(rst_int_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det), .sda_s(sda_s)
  );

  ee_proto #(.PAGE_BITS(PAGE_BITS), .AW(AW)) u_proto (
    .clk(clk), .rst_n(rst_int_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det), .sda_s(sda_s),
    .strap(strap_i), .rd_data(rd_data), .sda_oe(sda_oe_o), .ptr(ptr),
    .push(push), .push_data(push_data), .clr(clr), .commit(commit),
    .st(st), .bitcnt(bitcnt)
  );

  ee_store #(.AW(AW), .WR_BUF(WR_BUF)) u_store (
    .clk(clk), .rst_n(rst_int_n), .clr(clr), .push(push), .push_addr(ptr),
    .push_data(push_data), .commit(commit), .rd_addr(ptr), .rd_data(rd_data)
  );
endmodule

// File: rtl/ee_slave_chk.sv
module ee_slave_chk
  import ee_pkg::*;
(
  input logic      clk,
  input logic      rst_n,
  input logic      scl_i,
  input logic      sda_oe_o,
  input ee_state_e st,
  input logic [3:0] bitcnt,
  input logic      start_det,
  input logic      stop_det
);
  // R11
  oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe_o) |-> !scl_i);

  // R2 R8
  quiet_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE || st == ST_IGN) |-> !sda_oe_o);

  // R3
  ack_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe_o && st != ST_READ) |-> (bitcnt == 4'd0 || bitcnt == 4'd8));

  // R9
  start_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (st == ST_ADDR && bitcnt == 4'd0 && !sda_oe_o));

  // R4
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (st == ST_IDLE));
endmodule

bind ee_slave ee_slave_chk u_chk (.*);

// File: tb/test_ee_slave.sv
module test_ee_slave;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic m_sda = 1'b1;
  logic oe1, oe2;
  logic sda_bus;
  int   checks = 0, fails = 0, cyc = 0, r11_bad = 0;
  logic prev_oe = 1'b0;
  logic [7:0] expm [256];
  int   ptr_m = 0;

  always #5 clk = ~clk;
  assign sda_bus = m_sda & ~oe1 & ~oe2;

  ee_slave #(.PAGE_BITS(0), .WR_BUF(8)) i_ee_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus),
    .strap_i(3'b000), .sda_oe_o(oe1));

  ee_slave #(.PAGE_BITS(1), .WR_BUF(8)) i_ee_slave_pg (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus),
    .strap_i(3'b110), .sda_oe_o(oe2));

  task automatic chk(input logic ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, act, expv);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && (oe1 !== prev_oe) && scl) r11_bad++;
    prev_oe = oe1;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 190000) begin
      fails++;
      $display("FAIL watchdog: got %0d expected %0d", cyc, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks + 1, fails);
      $finish;
    end
  end

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    wt(6); m_sda = b; wt(6); scl = 1'b1; wt(8); scl = 1'b0;
  endtask

  task automatic recv_bit(output logic r);
    wt(6); m_sda = 1'b1; wt(6); scl = 1'b1; wt(4); r = sda_bus; wt(4); scl = 1'b0;
  endtask

  task automatic bus_start();
    if (!scl) begin
      wt(6); m_sda = 1'b1; wt(6); scl = 1'b1; wt(6);
    end
    m_sda = 1'b0; wt(6); scl = 1'b0;
  endtask

  task automatic bus_stop();
    wt(6); m_sda = 1'b0; wt(6); scl = 1'b1; wt(6); m_sda = 1'b1; wt(6);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    logic r;
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    recv_bit(r);
    acked = !r;
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] b);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      recv_bit(r);
      b[i] = r;
    end
    send_bit(!give_ack);
  endtask

  task automatic do_write(input int a, input int n);
    logic ak;
    logic [7:0] d [16];
    bus_start();
    send_byte(8'hA0, ak); chk(ak, "R2 addr ack", ak, 1);
    send_byte(8'(a), ak); chk(ak, "R3 word ack", ak, 1);
    for (int i = 0; i < n; i++) begin
      d[i] = 8'($urandom());
      send_byte(d[i], ak); chk(ak, "R3 data ack", ak, 1);
    end
    bus_stop();
    for (int i = 0; i < n && i < 8; i++) expm[(a + i) & 255] = d[i];
    ptr_m = (a + n) & 255;
  endtask

  task automatic do_rread(input int a, input int n, input string req);
    logic ak;
    logic [7:0] b;
    bus_start();
    send_byte(8'hA0, ak); chk(ak, "R5 addr ack", ak, 1);
    send_byte(8'(a), ak); chk(ak, "R5 word ack", ak, 1);
    bus_start();
    send_byte(8'hA1, ak); chk(ak, "R5 read addr ack", ak, 1);
    for (int i = 0; i < n; i++) begin
      recv_byte(i < n - 1, b);
      chk(b == expm[(a + i) & 255], req, b, expm[(a + i) & 255]);
    end
    bus_stop();
    ptr_m = (a + n) & 255;
  endtask

  task automatic do_cread(input string req);
    logic ak;
    logic [7:0] b;
    bus_start();
    send_byte(8'hA1, ak); chk(ak, "R7 addr ack", ak, 1);
    recv_byte(1'b0, b);
    chk(b == expm[ptr_m], req, b, expm[ptr_m]);
    bus_stop();
    ptr_m = (ptr_m + 1) & 255;
  endtask

  initial begin
    logic ak, r;
    logic [7:0] b, old10;
    void'($urandom(32'h5EED_0042));
    wt(4);
    chk(oe1 == 1'b0 && oe2 == 1'b0, "R1 reset oe", oe1, 0);
    rst_n = 1'b1;
    wt(10);
    chk(oe1 == 1'b0, "R1 idle oe", oe1, 0);

    // R3: fill the array in blocks of 8
    for (int blk = 0; blk < 32; blk++) do_write(blk * 8, 8);

    // R5 random reads
    do_rread(8'h37, 1, "R5 random read");
    do_rread(8'hC2, 1, "R5 random read");
    // R7 current address continues after the last read
    do_cread("R7 current read");
    do_cread("R7 current read 2");
    // R6 sequential read across the top of the array
    do_rread(8'hFC, 6, "R6 sequential wrap");
    do_cread("R6 R7 pointer after wrap");

    // R8 master NACK, slave must stay silent for a further byte
    bus_start();
    send_byte(8'hA0, ak); send_byte(8'h50, ak);
    bus_start();
    send_byte(8'hA1, ak);
    recv_byte(1'b0, b);
    chk(b == expm[8'h50], "R8 byte before nack", b, expm[8'h50]);
    for (int i = 0; i < 9; i++) begin
      recv_bit(r);
      chk(r == 1'b1, "R8 released after nack", r, 1);
    end
    bus_stop();
    ptr_m = 8'h51;
    do_cread("R8 next command works");

    // R2 mismatched strap and wrong device code
    bus_start();
    send_byte(8'hA2, ak); chk(!ak, "R2 strap mismatch nack", ak, 0);
    send_byte(8'h30, ak); chk(!ak, "R2 ignored byte nack", ak, 0);
    send_byte(8'hFF, ak); chk(!ak, "R2 ignored data nack", ak, 0);
    bus_stop();
    bus_start();
    send_byte(8'hB0, ak); chk(!ak, "R2 device code nack", ak, 0);
    bus_stop();
    do_rread(8'h30, 1, "R2 memory untouched");

    // R4 R7 pending byte discarded by repeated start
    old10 = expm[8'h10];
    bus_start();
    send_byte(8'hA0, ak); send_byte(8'h10, ak);
    send_byte(~old10, ak); chk(ak, "R4 data ack", ak, 1);
    bus_start();
    send_byte(8'hA1, ak); chk(ak, "R4 read ack", ak, 1);
    recv_byte(1'b0, b);
    chk(b == expm[8'h11], "R4 R7 pointer advanced by write", b, expm[8'h11]);
    bus_stop();
    do_rread(8'h10, 1, "R4 aborted write not stored");

    // R9 start in the middle of a byte
    bus_start();
    send_byte(8'hA0, ak); send_byte(8'h20, ak);
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    bus_start();
    send_byte(8'hA1, ak); chk(ak, "R9 restart addr ack", ak, 1);
    recv_byte(1'b0, b);
    chk(b == expm[8'h20], "R9 partial byte ignored", b, expm[8'h20]);
    bus_stop();
    ptr_m = 8'h21;

    // R10 more bytes than the buffer holds
    do_write(8'h40, 10);
    do_rread(8'h40, 10, "R10 overflow bytes dropped");
    do_rread(8'h40, 1, "R10 reread");
    ptr_m = 8'h41;
    bus_start(); send_byte(8'hA0, ak); send_byte(8'h80, ak);
    for (int i = 0; i < 11; i++) send_byte(8'(i), ak);
    bus_stop();
    for (int i = 0; i < 8; i++) expm[8'h80 + i] = 8'(i);
    ptr_m = 8'h8B;
    do_cread("R10 pointer advanced past dropped");

    // R12 page-select device
    bus_start(); send_byte(8'hAC, ak); chk(ak, "R12 page0 ack", ak, 1);
    send_byte(8'h05, ak); send_byte(8'h11, ak); bus_stop();
    bus_start(); send_byte(8'hAE, ak); chk(ak, "R12 page1 ack", ak, 1);
    send_byte(8'h05, ak); send_byte(8'h22, ak); bus_stop();
    bus_start(); send_byte(8'hAC, ak); send_byte(8'h05, ak);
    bus_start(); send_byte(8'hAD, ak); recv_byte(1'b0, b); bus_stop();
    chk(b == 8'h11, "R12 page0 data", b, 8'h11);
    bus_start(); send_byte(8'hAE, ak); send_byte(8'h05, ak);
    bus_start(); send_byte(8'hAF, ak); recv_byte(1'b0, b); bus_stop();
    chk(b == 8'h22, "R12 page1 data", b, 8'h22);

    // random mix of writes and reads
    for (int k = 0; k < 20; k++) begin
      int a, n;
      a = int'($urandom() & 255);
      n = 1 + int'($urandom() % 8);
      if ($urandom() % 2 == 0) do_write(a, n);
      else do_rread(a, n, "R6 random sequential read");
    end
    do_cread("R7 random tail");

    chk(r11_bad == 0, "R11 oe change with scl high", r11_bad, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule